// File: doc/BRIEF.md
# Sampling Converter Bus Sequencer

This block is the digital control side of a 10-bit sampling converter that a processor addresses like a memory location. The processor drives an active-low chip select together with an active-low sample strobe and an active-low read strobe. A sample request starts a conversion. The conversion captures the input-channel code, runs a coarse phase and then a fine phase, and latches the 10-bit result. Completion is signalled by pulling an active-low interrupt low. The result is placed on the data outputs whenever read and chip select are both low.

The analog front end is modelled as one digital sample word per input, supplied from outside. The coarse phase takes the upper six bits of the selected sample and the lower four bits of the same held value. The fine phase then assembles the full result. Two strobe styles are supported:
- In the separate-strobe style, the coarse phase lasts as long as the sample strobe is held, and its release starts a fine phase of fixed length.
- In the combined-strobe style, sample and read are pulled low together, and an internal counter times both phases.

Top module: `adc_bus_seq`

## Requirements
- R1: The sample and read strobes have no effect while `cs_n` is high: no conversion starts and `db_oe` stays 0.
- R2: The channel code on `chan_sel` is captured when a conversion starts. Code 0, 1, 2 and 3 selects sample word 0, 1, 2 and 3 of `samp_flat` (word k occupies bits k*10+9 down to k*10). Later changes of `chan_sel` do not affect that conversion.
- R3: Separate-strobe style (`mode_comb`=0). `busy` rises on the third rising clock edge after the gated sample strobe goes active. The coarse phase lasts while the strobe is held. The interrupt falls, and `busy` falls, on edge 3+FINE_CYC after the strobe is released.
- R4: Combined-strobe style (`mode_comb`=1). A conversion starts only when the sample and read strobes are both active. A sample strobe alone starts nothing. `int_n` falls on edge 3+COARSE_CYC+FINE_CYC after the strobes go active.
- R5: The result equals the selected sample word as it stood at the end of the coarse phase. Changes to the sample after that point are not seen.
- R6: `int_n` stays low after completion until the gated read strobe is released. It returns high on the third clock edge after that release.
- R7: `db_oe` is 1 exactly while `cs_n` and `rd_n` are both low, with no clock delay. `db_out` then shows the last result, and shows 0 otherwise.
- R8: In the combined-strobe style, the data outputs show the previous result throughout a conversion. They switch to the new result in the same cycle that `int_n` falls.
- R9: A sample request that arrives while a conversion is running is ignored. The running conversion finishes on time with its own channel, and no new conversion follows.
- R10: After reset, `busy` is 0, `int_n` is 1 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, gates both strobes |
| sh_n | input | 1 | Sample strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| mode_comb | input | 1 | 1 selects the combined-strobe style |
| chan_sel | input | SEL_W | Input channel code |
| samp_flat | input | NCH*RES | One digital sample word per input |
| busy | output | 1 | Conversion in progress |
| int_n | output | 1 | Completion interrupt, active low |
| db_out | output | RES | Data bus value |
| db_oe | output | 1 | Data bus drive enable |

## Verification
Every channel code is converted in both strobe styles. Each input carries a different sample word, so a wrong channel pick is visible in the result. Within a conversion, the chosen sample is overwritten right after the coarse phase ends and the channel code is flipped right after the start. This separates a correct hold from a design that reads live inputs. Interrupt and busy edges are checked one cycle before and exactly at their expected clock. This separates a correct phase count from one that is off by one. Negative patterns cover three cases: strobes with chip select high, a sample strobe without read in the combined style, and a second sample request during the fine phase. Each shows whether a stray request can start or disturb a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2
    } phase_e;

    // strobes after chip-select gating, active high
    typedef struct packed {
        logic sh;
        logic rd;
    } strobe_t;

    function automatic strobe_t gate_strobes(input logic cs_n, input logic sh_n,
                                             input logic rd_n);
        strobe_t s;
        s.sh = ~cs_n & ~sh_n;
        s.rd = ~cs_n & ~rd_n;
        return s;
    endfunction

    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] now_n,
    output logic [W-1:0] prev_n
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, sync_q, last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                last_q <= 1'b1;
            end else begin
                meta_q <= raw_n[g];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end
        assign now_n[g]  = sync_q;
        assign prev_n[g] = last_q;
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES        = 10,
    parameter int CRS        = 6,
    parameter int SEL_W      = 2,
    parameter int COARSE_CYC = 25,
    parameter int FINE_CYC   = 60
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode_comb,
    input  strobe_t                   now_s,
    input  strobe_t                   prev_s,
    input  logic [SEL_W-1:0]          chan_sel,
    input  logic [(1<<SEL_W)*RES-1:0] samp_flat,
    output logic                      busy,
    output logic                      int_n,
    output logic                      rd_rel,
    output logic [SEL_W-1:0]          chan_q,
    output logic [RES-1:0]            result_q
);
    localparam int NCH   = 1 << SEL_W;
    localparam int FINEB = RES - CRS;
    localparam int CMAX  = (COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC;
    localparam int CNT_W = count_width(CMAX);

    logic [RES-1:0] smp_arr [NCH];
    for (genvar g = 0; g < NCH; g++) begin : g_mux
        assign smp_arr[g] = samp_flat[g*RES +: RES];
    end

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CRS-1:0]   crs_q;
    logic [FINEB-1:0] low_q;
    logic [RES-1:0]   sel_smp;
    logic             sh_rise, sh_fall, start, coarse_done, fine_done;

    assign sel_smp     = smp_arr[chan_q];
    assign sh_rise     = now_s.sh & ~prev_s.sh;
    assign sh_fall     = ~now_s.sh & prev_s.sh;
    assign rd_rel      = ~now_s.rd & prev_s.rd;
    assign start       = (phase_q == PH_IDLE) && sh_rise && (!mode_comb || now_s.rd);
    assign coarse_done = (phase_q == PH_COARSE) &&
                         (mode_comb ? (cnt_q == CNT_W'(COARSE_CYC - 1)) : sh_fall);
    assign fine_done   = (phase_q == PH_FINE) && (cnt_q == CNT_W'(FINE_CYC - 1));
    assign busy        = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            chan_q   <= '0;
            crs_q    <= '0;
            low_q    <= '0;
            result_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_COARSE;
                        chan_q  <= chan_sel;
                        cnt_q   <= '0;
                    end
                end
                PH_COARSE: begin
                    if (coarse_done) begin
                        phase_q <= PH_FINE;
                        cnt_q   <= '0;
                        crs_q   <= sel_smp[RES-1 -: CRS];
                        low_q   <= sel_smp[FINEB-1:0];
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FINE: begin
                    if (fine_done) begin
                        phase_q  <= PH_IDLE;
                        result_q <= {crs_q, low_q};
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            int_n <= 1'b1;
        else if (fine_done) int_n <= 1'b0;
        else if (rd_rel)    int_n <= 1'b1;
    end
endmodule

// File: rtl/adc_bus_out.sv
module adc_bus_out #(
    parameter int RES = 10
) (
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic [RES-1:0] result,
    output logic [RES-1:0] db_out,
    output logic           db_oe
);
    assign db_oe  = ~cs_n & ~rd_n;
    assign db_out = db_oe ? result : '0;
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
    import adc_seq_pkg::*;
#(
    parameter int RES        = 10,
    parameter int CRS        = 6,
    parameter int SEL_W      = 2,
    parameter int COARSE_CYC = 25,
    parameter int FINE_CYC   = 60
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      sh_n,
    input  logic                      rd_n,
    input  logic                      mode_comb,
    input  logic [SEL_W-1:0]          chan_sel,
    input  logic [(1<<SEL_W)*RES-1:0] samp_flat,
    output logic                      busy,
    output logic                      int_n,
    output logic [RES-1:0]            db_out,
    output logic                      db_oe
);
    logic [2:0]       now_n, prev_n;
    strobe_t          now_s, prev_s;
    logic             rd_rel;
    logic [SEL_W-1:0] chan_q;
    logic [RES-1:0]   result_q;

    adc_strobe_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_n  ({cs_n, sh_n, rd_n}),
        .now_n  (now_n),
        .prev_n (prev_n)
    );

    assign now_s  = gate_strobes(now_n[2], now_n[1], now_n[0]);
    assign prev_s = gate_strobes(prev_n[2], prev_n[1], prev_n[0]);

    adc_conv_ctrl #(
        .RES(RES), .CRS(CRS), .SEL_W(SEL_W),
        .COARSE_CYC(COARSE_CYC), .FINE_CYC(FINE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode_comb (mode_comb),
        .now_s     (now_s),
        .prev_s    (prev_s),
        .chan_sel  (chan_sel),
        .samp_flat (samp_flat),
        .busy      (busy),
        .int_n     (int_n),
        .rd_rel    (rd_rel),
        .chan_q    (chan_q),
        .result_q  (result_q)
    );

    adc_bus_out #(.RES(RES)) u_bus (
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .result (result_q),
        .db_out (db_out),
        .db_oe  (db_oe)
    );
endmodule

// File: rtl/adc_bus_seq_chk.sv
module adc_bus_seq_chk #(
    parameter int RES   = 10,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             int_n,
    input logic             rd_rel,
    input logic             db_oe,
    input logic [RES-1:0]   db_out,
    input logic [SEL_W-1:0] chan_q,
    input logic [RES-1:0]   result_q
);
    // R3
    done_sets_int_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !int_n);

    // R6
    int_falls_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> $fell(busy));

    // R6
    int_clears_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_n) |-> $past(rd_rel));

    // R8
    result_held_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(result_q));

    // R2
    chan_held_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(chan_q));

    // R7
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !db_oe |-> (db_out == '0));
endmodule

bind adc_bus_seq adc_bus_seq_chk #(.RES(RES), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_adc_bus_seq.sv
module sim_adc_bus_seq;
    localparam int RES = 10;
    localparam int SEL_W = 2;
    localparam int NCH = 4;
    localparam int CC = 4;
    localparam int FC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sh_n = 1'b1, rd_n = 1'b1, mode_comb = 1'b0;
    logic [SEL_W-1:0] chan = '0;
    logic [NCH*RES-1:0] samp = '0;
    logic busy, int_n, db_oe;
    logic [RES-1:0] db_out;

    int n_chk = 0;
    int n_err = 0;
    int prev_res = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_bus_seq #(.RES(RES), .CRS(6), .SEL_W(SEL_W), .COARSE_CYC(CC), .FINE_CYC(FC)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
        .mode_comb(mode_comb), .chan_sel(chan), .samp_flat(samp),
        .busy(busy), .int_n(int_n), .db_out(db_out), .db_oe(db_oe)
    );

    task automatic eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic after(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int val_of(input int ch, input int it);
        return (ch * 293 + it * 157 + 37) % 1024;
    endfunction

    task automatic load(input int it);
        for (int c = 0; c < NCH; c++) samp[c*RES +: RES] = RES'(val_of(c, it));
    endtask

    task automatic conv_sep(input int ch, input int it, input bit retrig);
        int v;
        v = val_of(ch, it);
        load(it);
        chan = SEL_W'(ch); cs_n = 0; sh_n = 0;
        after(2); eq("R3 busy before start edge", busy, 0);
        after(1); eq("R3 busy at start edge", busy, 1);
        chan = chan ^ 2'b11;
        after(3); eq("R3 busy while strobe held", busy, 1);
        sh_n = 1;
        after(3);
        samp[ch*RES +: RES] = ~RES'(v);
        if (retrig) begin
            sh_n = 0; after(2); sh_n = 1; after(FC - 3);
        end else begin
            after(FC - 1);
        end
        eq("R3 int before fine end", int_n, 1);
        eq("R3 busy before fine end", busy, 1);
        after(1);
        eq("R3 int at fine end", int_n, 0);
        eq("R3 busy at fine end", busy, 0);
        after(3); eq("R6 int held without read", int_n, 0);
        rd_n = 0; #1;
        eq("R7 oe on read", db_oe, 1);
        eq("R2 R5 result", db_out, v);
        after(1); rd_n = 1; #1;
        eq("R7 oe off", db_oe, 0);
        eq("R7 bus quiet", db_out, 0);
        after(2); eq("R6 int before release edge", int_n, 0);
        after(1); eq("R6 int cleared", int_n, 1);
        if (retrig) begin
            after(4); eq("R9 no follow-up conversion", busy, 0);
        end
        cs_n = 1;
        after(2);
        prev_res = v;
    endtask

    task automatic conv_comb(input int ch, input int it);
        int v;
        v = val_of(ch, it);
        load(it);
        chan = SEL_W'(ch); cs_n = 0; sh_n = 0; rd_n = 0; #1;
        eq("R8 oe at start", db_oe, 1);
        eq("R8 old result at start", db_out, prev_res);
        after(3) ; eq("R4 busy at start edge", busy, 1);
        chan = chan ^ 2'b01;
        after(CC);
        samp[ch*RES +: RES] = ~RES'(v);
        after(FC - 1);
        eq("R4 int before end", int_n, 1);
        eq("R8 old result before end", db_out, prev_res);
        after(1);
        eq("R4 int at end", int_n, 0);
        eq("R8 R5 R2 new result at end", db_out, v);
        sh_n = 1; rd_n = 1;
        after(2); eq("R6 int before release edge", int_n, 0);
        after(1); eq("R6 int cleared", int_n, 1);
        cs_n = 1;
        after(2);
        prev_res = v;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        after(3);
        rst = 0;
        after(1);
        // R10 reset state
        eq("R10 busy", busy, 0);
        eq("R10 int", int_n, 1);
        cs_n = 0; rd_n = 0; #1;
        eq("R10 result zero", db_out, 0);
        rd_n = 1; after(1); cs_n = 1;
        after(3);

        // R1 chip select high blocks strobes
        sh_n = 0; after(5);
        eq("R1 no start with cs high", busy, 0);
        rd_n = 0; #1;
        eq("R1 no bus drive with cs high", db_oe, 0);
        rd_n = 1; sh_n = 1; after(1);
        cs_n = 0; after(4);
        eq("R1 no start without strobe edge", busy, 0);
        cs_n = 1; after(2);

        mode_comb = 0;
        for (int it = 0; it < 2; it++)
            for (int ch = 0; ch < NCH; ch++)
                conv_sep(ch, it, it == 1);

        // R4 sample strobe alone does nothing in combined style
        mode_comb = 1;
        cs_n = 0; sh_n = 0; after(5);
        eq("R4 no start without read", busy, 0);
        sh_n = 1; after(3); cs_n = 1; after(2);

        for (int it = 2; it < 4; it++)
            for (int ch = 0; ch < NCH; ch++)
                conv_comb(ch, it);

        done = 1;
        report();
        $finish;
    end
endmodule